// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block turns a peripheral clock into the timing base of an I2C bus engine. A first-stage prescaler divides the input clock by one plus a small divide field. The result is a one-cycle internal tick enable. A second stage counts those ticks to form one SCL period. The period is a fixed base of 20 ticks, plus 8 ticks per step of a 6-bit step field, plus a separate compensation count. The compensation count absorbs the edge times and the internal delay.

Software packs the step field above the divide field in one control word and supplies the compensation count on its own input. Values are chosen so that the internal tick stays below 20 MHz. The block drives an SCL level and three one-clock strobes: the start of the low phase, the start of the high phase, and the end of each completed period. A run input gates everything. While run is low, all counters are cleared and SCL is released high.

Top module: `scl_clkgen`

## Requirements
- R1: After reset, scl_level is 1 and tick_en, low_start, high_start and period_done are all 0.
- R2: While run is 1, tick_en is a one-clock pulse that repeats every D+1 clocks. D is the divide field, ctrl_word[DIV_W-1:0], with DIV_W=3 by default.
- R3: An SCL period lasts P internal ticks, that is P*(D+1) clocks between successive low_start pulses. P = 20 + 8*S + C, where S is the step field and C is comp.
- R4: The low phase lasts L = ceil(P/2) ticks, so high_start follows low_start by L*(D+1) clocks. The high phase takes the remaining P-L ticks. scl_level is 0 in the low phase and 1 in the high phase.
- R5: The step field S sits directly above the divide field, in ctrl_word[DIV_W+5:DIV_W].
- R6: While run is 0, the block shows scl_level 1 and no tick or strobe. After run rises, the first low_start appears D+2 clock edges later, counting the edge that first samples run high.
- R7: period_done pulses together with every low_start that ends a period. It does not pulse with the first low_start after run rises.
- R8: scl_level falls only together with low_start and rises only together with high_start. Outside of leaving the idle state, it never changes at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Enables the prescaler and the period counter |
| ctrl_word | input | DIV_W+6 | Step field above the divide field |
| comp | input | 5 | Compensation ticks added to each period |
| tick_en | output | 1 | One-clock internal tick enable |
| scl_level | output | 1 | SCL level to drive (1 = released) |
| low_start | output | 1 | Strobe: the low phase begins |
| high_start | output | 1 | Strobe: the high phase begins |
| period_done | output | 1 | Strobe: a full period has completed |

## Verification
The assertions check three things on every cycle. First, the spacing of tick pulses against the divide field. Second, that every SCL edge coincides with its strobe and that the two phase strobes never overlap. Third, that period_done only comes with low_start and that idle means silence. Only the bench's scenarios can show the actual lengths of the period and of the low phase. The same holds for the restart latency after run rises and for the split of odd periods. The bench measures these in clocks for directed extreme settings and for random field values.

// File: rtl/scl_clk_pkg.sv
// Shared constants and helper functions for the SCL clock divider.
// Assumes period lengths fit in 32-bit unsigned arithmetic.
package scl_clk_pkg;
    localparam int unsigned BASE_TICKS = 20;
    localparam int unsigned STEP_TICKS = 8;

    // Length of the low phase: half the period, rounded up.
    function automatic int unsigned low_share(input int unsigned per);
        return (per + 1) / 2;
    endfunction
endpackage

// File: rtl/scl_prescaler.sv
// First-stage divider: emits a one-clock tick every (div+1) clocks while run is high.
// Assumes div is held stable while run is high.
module scl_prescaler #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Count clocks up to div, pulse tick on wrap, and clear while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == div) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/scl_period_calc.sv
// Combinational period arithmetic: total ticks and low-phase ticks.
// Assumes PER_W is wide enough for the largest period.
module scl_period_calc #(
    parameter int STEP_W = 6,
    parameter int COMP_W = 5,
    parameter int PER_W  = 10
) (
    input  logic [STEP_W-1:0] step,
    input  logic [COMP_W-1:0] comp,
    output logic [PER_W-1:0]  per_len,
    output logic [PER_W-1:0]  low_len
);
    import scl_clk_pkg::*;

    int unsigned per_full;

    // Base plus scaled step plus compensation, then the rounded-up half.
    always_comb begin
        per_full = BASE_TICKS + STEP_TICKS * int'(step) + int'(comp);
        per_len  = PER_W'(per_full);
        low_len  = PER_W'(low_share(per_full));
    end
endmodule

// File: rtl/scl_phase_gen.sv
// Second stage: counts ticks through one SCL period, drives the level and strobes.
// Assumes per_len and low_len are stable while run is high, with low_len < per_len.
module scl_phase_gen #(
    parameter int PER_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [PER_W-1:0] per_len,
    input  logic [PER_W-1:0] low_len,
    output logic             scl,
    output logic             lo_stb,
    output logic             hi_stb,
    output logic             done_stb
);
    logic             active;
    logic [PER_W-1:0] tcnt;

    // Walk the tick counter through the period and emit one-clock strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            active   <= 1'b0;
            tcnt     <= '0;
            scl      <= 1'b1;
            lo_stb   <= 1'b0;
            hi_stb   <= 1'b0;
            done_stb <= 1'b0;
        end else begin
            lo_stb   <= 1'b0;
            hi_stb   <= 1'b0;
            done_stb <= 1'b0;
            if (tick) begin
                if (!active) begin
                    active <= 1'b1;
                    tcnt   <= '0;
                    scl    <= 1'b0;
                    lo_stb <= 1'b1;
                end else if (tcnt == per_len - 1'b1) begin
                    tcnt     <= '0;
                    scl      <= 1'b0;
                    lo_stb   <= 1'b1;
                    done_stb <= 1'b1;
                end else begin
                    tcnt <= tcnt + 1'b1;
                    if (tcnt + 1'b1 == low_len) begin
                        scl    <= 1'b1;
                        hi_stb <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/scl_clkgen.sv
// Top of the SCL clock divider: splits the control word and chains the two stages.
// Assumes ctrl_word and comp are held stable while run is high.
module scl_clkgen #(
    parameter int DIV_W  = 3,
    parameter int STEP_W = 6,
    parameter int COMP_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic [DIV_W+STEP_W-1:0] ctrl_word,
    input  logic [COMP_W-1:0]       comp,
    output logic                    tick_en,
    output logic                    scl_level,
    output logic                    low_start,
    output logic                    high_start,
    output logic                    period_done
);
    localparam int MAX_PER = 20 + 8 * ((1 << STEP_W) - 1) + (1 << COMP_W) - 1;
    localparam int PER_W   = $clog2(MAX_PER + 1);

    logic [DIV_W-1:0]  div_f;
    logic [STEP_W-1:0] step_f;
    logic [PER_W-1:0]  per_len;
    logic [PER_W-1:0]  low_len;

    // Field split: step field sits above the divide field.
    assign div_f  = ctrl_word[DIV_W-1:0];
    assign step_f = ctrl_word[DIV_W+STEP_W-1:DIV_W];

    scl_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div_f), .tick(tick_en)
    );

    scl_period_calc #(.STEP_W(STEP_W), .COMP_W(COMP_W), .PER_W(PER_W)) u_calc (
        .step(step_f), .comp(comp), .per_len(per_len), .low_len(low_len)
    );

    scl_phase_gen #(.PER_W(PER_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick_en),
        .per_len(per_len), .low_len(low_len),
        .scl(scl_level), .lo_stb(low_start), .hi_stb(high_start),
        .done_stb(period_done)
    );
endmodule

// File: rtl/scl_clkgen_chk.sv
// Checker for scl_clkgen: tick spacing, edge/strobe alignment and idle behaviour.
// Assumes the configuration stays stable while run is high.
module scl_clkgen_chk #(
    parameter int DIV_W  = 3,
    parameter int STEP_W = 6,
    parameter int COMP_W = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    run,
    input logic [DIV_W+STEP_W-1:0] ctrl_word,
    input logic [COMP_W-1:0]       comp,
    input logic                    tick_en,
    input logic                    scl_level,
    input logic                    low_start,
    input logic                    high_start,
    input logic                    period_done
);
    logic [DIV_W:0] gap;

    // Clocks since the previous tick, restarted at one on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) gap <= '0;
        else if (tick_en)   gap <= 1;
        else                gap <= gap + 1'b1;
    end

    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en) |-> (gap == {1'b0, ctrl_word[DIV_W-1:0]} + 1'b1));

    p_fall_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_level) |-> low_start);

    p_rise_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_level) && $past(run)) |-> high_start);

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({low_start, high_start}));

    p_done_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        period_done |-> low_start);

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (scl_level && !tick_en && !low_start && !high_start && !period_done));
endmodule

bind scl_clkgen scl_clkgen_chk #(.DIV_W(DIV_W), .STEP_W(STEP_W), .COMP_W(COMP_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .ctrl_word(ctrl_word), .comp(comp),
    .tick_en(tick_en), .scl_level(scl_level), .low_start(low_start),
    .high_start(high_start), .period_done(period_done)
);

// File: tb/test_scl_clkgen.sv
// Bench for scl_clkgen: directed extremes plus seeded random field values.
module test_scl_clkgen;
    localparam int DIV_W = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [8:0] ctrl_word = '0;
    logic [4:0] comp = '0;
    logic       tick_en, scl_level, low_start, high_start, period_done;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    scl_clkgen i_scl_clkgen (
        .clk(clk), .rst_n(rst_n), .run(run), .ctrl_word(ctrl_word), .comp(comp),
        .tick_en(tick_en), .scl_level(scl_level), .low_start(low_start),
        .high_start(high_start), .period_done(period_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_period(input int s, input int c);
        return 20 + 8 * s + c;
    endfunction

    function automatic int exp_low(input int p);
        return (p + 1) / 2;
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic run_case(input int d, input int s, input int c);
        int n;
        int p;
        int l;
        int t;
        p = exp_period(s, c);
        l = exp_low(p);
        @(negedge clk);
        run = 1'b0;
        ctrl_word = 9'((s << DIV_W) | d);   // R5: step field above divide field
        comp = 5'(c);
        repeat (3) @(negedge clk);
        check(scl_level && !tick_en && !low_start && !high_start && !period_done,
              "R6 idle", int'({scl_level, tick_en, low_start, high_start, period_done}), 16);
        run = 1'b1;
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!low_start && n < 5000);
        check(n == d + 2, "R6 restart latency", n, d + 2);
        check(!period_done, "R7 no done at first low", int'(period_done), 0);
        check(!scl_level, "R4 low level", int'(scl_level), 0);
        t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (!high_start && t < 10000);
        check(t == l * (d + 1), "R4 low phase clocks", t, l * (d + 1));
        check(scl_level, "R4 high level", int'(scl_level), 1);
        do begin
            @(negedge clk);
            t++;
        end while (!low_start && t < 10000);
        check(t == p * (d + 1), "R3 R5 period clocks", t, p * (d + 1));
        check(period_done, "R7 done with low_start", int'(period_done), 1);
        while (!tick_en) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick_en && n < 100);
        check(n == d + 1, "R2 tick spacing", n, d + 1);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        check(scl_level && !tick_en && !low_start && !high_start && !period_done,
              "R1 reset state", int'({scl_level, tick_en, low_start, high_start, period_done}), 16);
        rst_n = 1'b1;
        @(negedge clk);
        check(scl_level && !low_start, "R1 after reset release", int'(scl_level), 1);
        run_case(0, 0, 0);      // shortest period, even
        run_case(0, 0, 1);      // odd period: low takes the extra tick
        run_case(7, 63, 31);    // longest period, slowest prescale
        run_case(2, 5, 7);
        for (int k = 0; k < 10; k++) begin
            run_case(int'($urandom_range(0, 7)), int'($urandom_range(0, 31)),
                     int'($urandom_range(0, 31)));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule